// File: doc/BRIEF.md
# Six-Decade Predetermining BCD Up/Down Counter

This block is a six-digit decimal counter that runs in either direction on a synchronous one-cycle count strobe. Three six-digit BCD values are supplied from outside: a reload value, a main target and an early-warning target. Comparators against these values drive three flags: a zero flag, a main-target flag and a warning flag. The reload value and the two targets are held by a neighbouring block and must always be valid BCD.

A prescaler sits in front of the counter, so the count advances on every strobe, every fifth strobe or every sixth strobe. In automatic mode the counter reloads itself on the clock edge that follows a match. A down step that reaches zero copies the reload value into the count. An up step that reaches the main target clears the count. After either reload the matching flag is held high for a fixed number of cycles. In manual mode neither reload happens. The count then waits at its value and the flags stay high until the next strobe or an explicit command clears them.

A small state machine times the pulses that follow a reload. It has three states. `S_RUN` is idle. `S_ZHOLD` stretches the zero flag after an automatic reload. `S_MHOLD` stretches the main flag after an automatic clear. The transitions are as follows:
- RUN→ZHOLD on a zero reload.
- RUN→MHOLD on a main clear.
- ZHOLD↔MHOLD when a new reload of the other kind arrives.
- A reload of the same kind restarts the timer.
- Any hold state goes back to RUN when its timer runs out, or at once on `clr`.

Top module: `predet_counter`

## Requirements
- R1: The count is six BCD nibbles, and nibble k holds decimal digit k, with k=0 the least significant. Each nibble stays in 0..9. An up step turns 9 into 0 with a carry into the next digit, and 999999 steps up to 000000. A down step turns 0 into 9 with a borrow, and 000000 steps down to 999999. `dir_up`=1 counts up.
- R2: `clr` takes priority over every other input. On the next edge the count is 000000, the prescaler is cleared, `main_out` and `warn_out` are low, and any hold pulse ends.
- R3: `load_pre` (when `clr` is low) copies `preset_bcd` into the count on the next edge. It takes priority over any step or automatic reload in that edge.
- R4: `div_sel` sets the prescaler ratio. 2'b01 advances the count on every 5th strobe, 2'b10 on every 6th strobe, and 2'b00 or 2'b11 on every strobe. Strobes are counted from the last advance or the last `clr`.
- R5: `zero_out` is high in every cycle in which the count is 000000.
- R6: In automatic mode (`auto_mode`=1), a down step that lands on 000000 causes `preset_bcd` to be loaded on the following edge. `zero_out` is then high for exactly HOLD_CYC cycles in total, counting from the match cycle.
- R7: In manual mode, a count at 000000 stays there, with `zero_out` high, until a load or an advancing strobe arrives.
- R8: In automatic mode, an up step that lands on `main_bcd` causes the count to be cleared to 000000 on the following edge. `main_out` is then high for exactly HOLD_CYC cycles in total.
- R9: A step that lands on `main_bcd` without an automatic clear sets `main_out`. It stays high until the next `cnt_stb` (even one the prescaler absorbs) or `clr`.
- R10: A step that lands on `warn_bcd` sets `warn_out`. It stays high until the next `cnt_stb`, `clr` or `load_pre`.
- R11: An automatic reload or clear wins over a step that would occur in the same edge. That step is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of count, prescaler and flags |
| cnt_stb | input | 1 | One-cycle count strobe |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| load_pre | input | 1 | Load reload value into the count |
| auto_mode | input | 1 | 1 = automatic reloads, 0 = manual |
| div_sel | input | 2 | Prescaler select (01 ÷5, 10 ÷6, else ÷1) |
| preset_bcd | input | 24 | Reload value, six BCD digits |
| main_bcd | input | 24 | Main target, six BCD digits |
| warn_bcd | input | 24 | Warning target, six BCD digits |
| count_bcd | output | 24 | Current count, six BCD digits |
| zero_out | output | 1 | Zero flag |
| main_out | output | 1 | Main-target flag |
| warn_out | output | 1 | Warning flag |

## Verification
Directed sequences cover several cases:
- Loads of 000009 and 999999 show carry and borrow ripple across digits, as opposed to changes in only the last digit.
- Strobe trains under each `div_sel` value show the prescaler ratio, as opposed to counting every strobe.
- Runs to zero and to the main target, once per mode, show whether a reload followed the match and how long the flag stayed high.
- A strobe placed in the match cycle shows that the reload wins over the step.

A long seeded random run then mixes these situations. It covers direction flips, sparse clears and loads, mode and ratio changes, and small target values, so that matches occur often. Every cycle of the run is compared against a reference model in the bench.

// File: rtl/predet_pkg.sv
package predet_pkg;

    typedef enum logic [1:0] {
        S_RUN   = 2'd0,
        S_ZHOLD = 2'd1,
        S_MHOLD = 2'd2
    } hold_state_t;

    localparam int PS_W = 3;

    function automatic logic [PS_W-1:0] div_limit(input logic [1:0] sel);
        unique case (sel)
            2'b01:   div_limit = 3'd5;
            2'b10:   div_limit = 3'd6;
            default: div_limit = 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/predet_prescaler.sv
module predet_prescaler
    import predet_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       stb,
    input  logic [1:0] div_sel,
    output logic       adv
);

    logic [PS_W-1:0] pcnt;
    logic [PS_W-1:0] lim;

    always_comb begin
        lim = div_limit(div_sel);
        adv = stb && (pcnt >= (lim - 3'd1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (clr) begin
            pcnt <= '0;
        end else if (stb) begin
            if (adv) pcnt <= '0;
            else     pcnt <= pcnt + 3'd1;
        end
    end

    // R4: with ratio one, every strobe advances
    p_div1_every_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && (div_sel == 2'b00 || div_sel == 2'b11)) |-> adv);

    // R4: the strobe tally never exceeds the largest ratio
    p_pcnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt < 3'd6);

    // R2: clear empties the tally
    p_clr_tally_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> pcnt == '0);

endmodule

// File: rtl/predet_bcd_step.sv
module predet_bcd_step #(
    parameter int DIGITS = 6
) (
    input  logic [4*DIGITS-1:0] cur,
    input  logic                up,
    output logic [4*DIGITS-1:0] nxt
);

    logic [DIGITS:0] ripple;

    assign ripple[0] = 1'b1;

    for (genvar g = 0; g < DIGITS; g++) begin : g_dec
        logic [3:0] d;
        logic [3:0] dn;
        logic       rout;

        assign d = cur[4*g +: 4];

        always_comb begin
            dn   = d;
            rout = 1'b0;
            if (ripple[g]) begin
                if (up) begin
                    if (d >= 4'd9) begin
                        dn   = 4'd0;
                        rout = 1'b1;
                    end else begin
                        dn = d + 4'd1;
                    end
                end else begin
                    if (d == 4'd0) begin
                        dn   = 4'd9;
                        rout = 1'b1;
                    end else begin
                        dn = d - 4'd1;
                    end
                end
            end
        end

        assign nxt[4*g +: 4] = dn;
        assign ripple[g+1]   = rout;
    end

endmodule

// File: rtl/predet_hold_fsm.sv
module predet_hold_fsm
    import predet_pkg::*;
#(
    parameter int HOLD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic zero_rl,
    input  logic main_rl,
    output logic zhold,
    output logic mhold
);

    localparam int TW = $clog2(HOLD_CYC + 1);
    localparam logic [TW-1:0] T_START = TW'(HOLD_CYC - 1);

    hold_state_t state, state_n;
    logic [TW-1:0] tmr, tmr_n;

    always_comb begin
        state_n = state;
        tmr_n   = tmr;
        if (clr) begin
            state_n = S_RUN;
            tmr_n   = '0;
        end else if (zero_rl) begin
            state_n = S_ZHOLD;
            tmr_n   = T_START;
        end else if (main_rl) begin
            state_n = S_MHOLD;
            tmr_n   = T_START;
        end else begin
            unique case (state)
                S_RUN: begin
                    tmr_n = '0;
                end
                S_ZHOLD, S_MHOLD: begin
                    if (tmr <= TW'(1)) begin
                        state_n = S_RUN;
                        tmr_n   = '0;
                    end else begin
                        tmr_n = tmr - TW'(1);
                    end
                end
                default: begin
                    state_n = S_RUN;
                    tmr_n   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_RUN;
            tmr   <= '0;
        end else begin
            state <= state_n;
            tmr   <= tmr_n;
        end
    end

    always_comb begin
        zhold = 1'b0;
        mhold = 1'b0;
        unique case (state)
            S_ZHOLD: zhold = 1'b1;
            S_MHOLD: mhold = 1'b1;
            default: ;
        endcase
    end

    initial begin
        if (HOLD_CYC < 2) $error("HOLD_CYC must be at least 2");
    end

    // R6: a zero reload starts the zero hold
    p_zhold_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_rl && !clr) |=> zhold);

    // R8: a main clear starts the main hold
    p_mhold_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (main_rl && !zero_rl && !clr) |=> mhold);

    // R2: clear ends any hold
    p_hold_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!zhold && !mhold));

endmodule

// File: rtl/predet_counter.sv
module predet_counter
    import predet_pkg::*;
#(
    parameter int DIGITS   = 6,
    parameter int HOLD_CYC = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                cnt_stb,
    input  logic                dir_up,
    input  logic                load_pre,
    input  logic                auto_mode,
    input  logic [1:0]          div_sel,
    input  logic [4*DIGITS-1:0] preset_bcd,
    input  logic [4*DIGITS-1:0] main_bcd,
    input  logic [4*DIGITS-1:0] warn_bcd,
    output logic [4*DIGITS-1:0] count_bcd,
    output logic                zero_out,
    output logic                main_out,
    output logic                warn_out
);

    localparam int CW = 4 * DIGITS;

    logic [CW-1:0] count_r;
    logic [CW-1:0] step_val;
    logic          adv;
    logic          stepped_dn, stepped_up;
    logic          main_lat, warn_lat;
    logic          is_zero, at_main;
    logic          zero_rl, main_rl;
    logic          zero_rl_eff, main_rl_eff;
    logic          step_en;
    logic          zhold, mhold;

    predet_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .stb     (cnt_stb),
        .div_sel (div_sel),
        .adv     (adv)
    );

    predet_bcd_step #(.DIGITS(DIGITS)) u_step (
        .cur (count_r),
        .up  (dir_up),
        .nxt (step_val)
    );

    predet_hold_fsm #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .zero_rl (zero_rl_eff),
        .main_rl (main_rl_eff),
        .zhold   (zhold),
        .mhold   (mhold)
    );

    always_comb begin
        is_zero     = (count_r == '0);
        at_main     = (count_r == main_bcd);
        zero_rl     = auto_mode && stepped_dn && is_zero;
        main_rl     = auto_mode && stepped_up && at_main;
        zero_rl_eff = zero_rl && !load_pre;
        main_rl_eff = main_rl && !load_pre;
        step_en     = adv && !clr && !load_pre && !zero_rl && !main_rl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_r <= '0;
        end else if (clr) begin
            count_r <= '0;
        end else if (load_pre || zero_rl) begin
            count_r <= preset_bcd;
        end else if (main_rl) begin
            count_r <= '0;
        end else if (step_en) begin
            count_r <= step_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stepped_dn <= 1'b0;
            stepped_up <= 1'b0;
        end else begin
            stepped_dn <= step_en && !dir_up;
            stepped_up <= step_en && dir_up;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_lat <= 1'b0;
        end else if (clr || main_rl_eff) begin
            main_lat <= 1'b0;
        end else if (step_en && (step_val == main_bcd)) begin
            main_lat <= 1'b1;
        end else if (cnt_stb) begin
            main_lat <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warn_lat <= 1'b0;
        end else if (clr || load_pre) begin
            warn_lat <= 1'b0;
        end else if (step_en && (step_val == warn_bcd)) begin
            warn_lat <= 1'b1;
        end else if (cnt_stb) begin
            warn_lat <= 1'b0;
        end
    end

    assign count_bcd = count_r;
    assign zero_out  = is_zero || zhold;
    assign main_out  = main_lat || mhold;
    assign warn_out  = warn_lat;

    for (genvar g = 0; g < DIGITS; g++) begin : g_chk
        // R1: every digit stays a decimal digit
        p_digit_ok_r1: assert property (@(posedge clk) disable iff (!rst_n)
            count_r[4*g +: 4] <= 4'd9);
    end

    // R2: clear empties count and flags
    p_clr_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count_bcd == '0 && !main_out && !warn_out));

    // R3: load copies the reload value
    p_load_val_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load_pre) |=> count_bcd == $past(preset_bcd));

    // R7: manual zero is held without load or advance
    p_manual_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_mode && count_bcd == '0 && !cnt_stb && !load_pre && !clr)
        |=> (count_bcd == '0 && zero_out));

    // R8: automatic clear after a main match
    p_auto_main_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (main_rl && !clr && !load_pre) |=> (count_bcd == '0 && main_out));

    // R10: warning drops on clear or load
    p_warn_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr || load_pre) |=> !warn_out);

endmodule

// File: tb/predet_counter_bench.sv
`timescale 1ns/1ps
module predet_counter_bench;

    localparam int DIGITS   = 6;
    localparam int HOLD_CYC = 2;
    localparam int MODV     = 1000000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0, cnt_stb = 1'b0, dir_up = 1'b1, load_pre = 1'b0;
    logic        auto_mode = 1'b0;
    logic [1:0]  div_sel = 2'b00;
    logic [23:0] preset_bcd, main_bcd, warn_bcd;
    logic [23:0] count_bcd;
    logic        zero_out, main_out, warn_out;

    int preset_i = 0, main_i = 999, warn_i = 998;
    int checks = 0, fails = 0;

    int m_cnt, m_pc, m_hz, m_hm;
    bit m_sdn, m_sup, m_ml, m_wl;

    always #4 clk = ~clk;

    function automatic logic [23:0] to_bcd(input int v);
        logic [23:0] r;
        int t;
        t = v;
        for (int i = 0; i < 6; i++) begin
            r[4*i +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    always_comb begin
        preset_bcd = to_bcd(preset_i);
        main_bcd   = to_bcd(main_i);
        warn_bcd   = to_bcd(warn_i);
    end

    predet_counter #(.DIGITS(DIGITS), .HOLD_CYC(HOLD_CYC)) u_predet_counter (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cnt_stb(cnt_stb), .dir_up(dir_up),
        .load_pre(load_pre), .auto_mode(auto_mode), .div_sel(div_sel),
        .preset_bcd(preset_bcd), .main_bcd(main_bcd), .warn_bcd(warn_bcd),
        .count_bcd(count_bcd), .zero_out(zero_out), .main_out(main_out),
        .warn_out(warn_out)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "count", int'(count_bcd), int'(to_bcd(m_cnt)));
        chk(tag, "zero_out", int'(zero_out), int'(m_cnt == 0 || m_hz > 0));
        chk(tag, "main_out", int'(main_out), int'(m_ml || m_hm > 0));
        chk(tag, "warn_out", int'(warn_out), int'(m_wl));
    endtask

    function automatic int ratio(input logic [1:0] s);
        return (s == 2'b01) ? 5 : (s == 2'b10) ? 6 : 1;
    endfunction

    task automatic model_edge();
        bit adv, zrl, mrl, step;
        int nv;
        adv  = cnt_stb && (m_pc >= ratio(div_sel) - 1);
        zrl  = auto_mode && m_sdn && (m_cnt == 0);
        mrl  = auto_mode && m_sup && (m_cnt == main_i);
        step = adv && !clr && !load_pre && !zrl && !mrl;
        nv   = dir_up ? (m_cnt + 1) % MODV : (m_cnt + MODV - 1) % MODV;
        if (clr) begin
            m_ml = 0;
        end else if (mrl && !load_pre) begin
            m_ml = 0;
        end else if (step && nv == main_i) begin
            m_ml = 1;
        end else if (cnt_stb) begin
            m_ml = 0;
        end
        if (clr || load_pre) m_wl = 0;
        else if (step && nv == warn_i) m_wl = 1;
        else if (cnt_stb) m_wl = 0;
        if (clr) begin
            m_hz = 0; m_hm = 0;
        end else if (zrl && !load_pre) begin
            m_hz = HOLD_CYC - 1; m_hm = 0;
        end else if (mrl && !load_pre) begin
            m_hm = HOLD_CYC - 1; m_hz = 0;
        end else begin
            if (m_hz > 0) m_hz--;
            if (m_hm > 0) m_hm--;
        end
        if (clr) m_pc = 0;
        else if (cnt_stb) m_pc = adv ? 0 : m_pc + 1;
        if (clr) m_cnt = 0;
        else if (load_pre || zrl) m_cnt = preset_i;
        else if (mrl) m_cnt = 0;
        else if (step) m_cnt = nv;
        m_sdn = step && !dir_up;
        m_sup = step && dir_up;
    endtask

    task automatic cyc(input string tag);
        compare(tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        clr = 0; cnt_stb = 0; load_pre = 0;
    endtask

    task automatic do_load(input int v, input string tag);
        preset_i = v; load_pre = 1; cyc(tag);
    endtask

    task automatic strobes(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            cnt_stb = 1; cyc(tag);
        end
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int seed;
        seed = 20240611;
        void'($urandom(seed));
        m_cnt = 0; m_pc = 0; m_hz = 0; m_hm = 0;
        m_sdn = 0; m_sup = 0; m_ml = 0; m_wl = 0;
        repeat (3) @(negedge clk);
        compare("R2 reset");
        rst_n = 1;
        @(negedge clk);

        // R1 carry and wrap
        dir_up = 1;
        do_load(9, "R3 load");
        strobes(1, "R1 carry");
        chk("R1", "carry 9->10", int'(count_bcd), int'(to_bcd(10)));
        do_load(999999, "R3 load");
        strobes(1, "R1 wrap up");
        chk("R1", "wrap to 0", int'(count_bcd), 0);
        chk("R5", "zero at 0", int'(zero_out), 1);
        dir_up = 0;
        strobes(1, "R1 wrap down");
        chk("R1", "wrap to 999999", int'(count_bcd), int'(to_bcd(999999)));

        // R3 load beats count
        preset_i = 1234; load_pre = 1; cnt_stb = 1; cyc("R3 priority");
        chk("R3", "load over step", int'(count_bcd), int'(to_bcd(1234)));

        // R2 clear beats load
        clr = 1; load_pre = 1; cnt_stb = 1; cyc("R2 priority");
        chk("R2", "clear wins", int'(count_bcd), 0);

        // R4 prescaler ratios
        dir_up = 1;
        div_sel = 2'b01;
        strobes(4, "R4 div5");
        chk("R4", "div5 held", int'(count_bcd), 0);
        strobes(1, "R4 div5");
        chk("R4", "div5 advance", int'(count_bcd), 1);
        div_sel = 2'b10;
        strobes(5, "R4 div6");
        chk("R4", "div6 held", int'(count_bcd), 1);
        strobes(1, "R4 div6");
        chk("R4", "div6 advance", int'(count_bcd), 2);
        div_sel = 2'b11;
        strobes(3, "R4 div1");
        chk("R4", "div1 every", int'(count_bcd), 5);
        div_sel = 2'b00;

        // R7 manual down to zero holds
        auto_mode = 0; dir_up = 0;
        do_load(2, "R3 load");
        strobes(2, "R7 down");
        repeat (4) cyc("R7 hold");
        chk("R7", "held zero", int'(count_bcd), 0);
        chk("R7", "zero high", int'(zero_out), 1);

        // R6 automatic zero reload with pulse length
        auto_mode = 1;
        do_load(3, "R3 load");
        preset_i = 3;
        strobes(3, "R6 down");
        chk("R6", "match cycle zero", int'(zero_out), 1);
        cyc("R6 reload");
        chk("R6", "reloaded", int'(count_bcd), 3);
        chk("R6", "pulse hold", int'(zero_out), 1);
        cyc("R6 end");
        chk("R6", "pulse ended", int'(zero_out), 0);

        // R11 reload wins over same-edge strobe
        strobes(3, "R11 down");
        cnt_stb = 1; cyc("R11 race");
        chk("R11", "step dropped", int'(count_bcd), 3);

        // R8 automatic main clear
        dir_up = 1; main_i = 5;
        do_load(3, "R3 load");
        strobes(2, "R8 up");
        chk("R8", "match main", int'(main_out), 1);
        cyc("R8 clear");
        chk("R8", "cleared", int'(count_bcd), 0);
        chk("R8", "pulse hold", int'(main_out), 1);
        cyc("R8 end");
        chk("R8", "pulse ended", int'(main_out), 0);

        // R9 manual main latch, dropped by absorbed strobe
        auto_mode = 0;
        strobes(5, "R9 up");
        repeat (3) cyc("R9 hold");
        chk("R9", "main held", int'(main_out), 1);
        div_sel = 2'b01;
        strobes(1, "R9 drop");
        chk("R9", "dropped by strobe", int'(main_out), 0);
        chk("R9", "count unchanged", int'(count_bcd), int'(to_bcd(5)));
        div_sel = 2'b00;
        clr = 1; cyc("R2 clr");

        // R10 warning latch
        warn_i = 2;
        strobes(2, "R10 up");
        repeat (2) cyc("R10 hold");
        chk("R10", "warn held", int'(warn_out), 1);
        do_load(7, "R10 load");
        chk("R10", "warn cleared by load", int'(warn_out), 0);

        // random phase
        for (int n = 0; n < 6000; n++) begin
            if (n % 500 == 0) begin
                preset_i = $urandom_range(0, 20);
                main_i   = $urandom_range(1, 25);
                warn_i   = $urandom_range(0, 25);
            end
            cnt_stb   = ($urandom_range(0, 9) < 6);
            clr       = ($urandom_range(0, 199) == 0);
            load_pre  = ($urandom_range(0, 49) == 0);
            if ($urandom_range(0, 19) == 0) dir_up = ~dir_up;
            if ($urandom_range(0, 99) < 2) auto_mode = ~auto_mode;
            if ($urandom_range(0, 99) < 2) div_sel = 2'($urandom_range(0, 3));
            cyc("R1 R5 R6 R8 R9 R10 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule